// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps the time of day and the calendar date as six packed-BCD bytes: seconds, minutes, hours (24-hour form), day of month, month and a two-digit year that stands for 2000 to 2099. A single-cycle enable from a 32768 Hz reference drives a prescaler. Each time the prescaler wraps, the whole date and time advances by one second in a single clock cycle. The carry runs from seconds up to the year, with month lengths and leap years taken into account.

Software reaches the block through a byte-wide register port, which decodes reads combinationally and applies writes on the clock edge. A run bit starts and freezes counting. A busy flag rises a fixed number of reference ticks before every rollover and drops on the edge that applies it, so software can avoid reading or writing a field while it changes. One-cycle pulses mark each second, minute, hour and day boundary. The same pulses appear as status bits.

A control state machine has three states: `ST_HALT` (stopped), `ST_RUN` (counting, access safe) and `ST_BUSY` (counting, rollover close). Its transitions are:
- `HALT_TO_RUN`: the run bit is set and the prescaler is outside the busy window.
- `HALT_TO_BUSY`: the run bit is set and the prescaler is inside the busy window.
- `RUN_TO_BUSY`: a tick brings the prescaler into the window.
- `BUSY_TO_RUN`: either the prescaler wraps, or the seconds field is written.
- `ANY_TO_HALT`: the run bit is cleared.

Top module: `bcd_clock_core`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01 and year 0x00, the control byte reads 0x00 and the status byte reads 0x00.
- R2: The register map is as follows.
  - Seconds is at address 0x00, minutes at 0x04, hours at 0x08, day at 0x0C, month at 0x10 and year at 0x14. Each is one packed-BCD byte.
  - The control byte is at 0x20. Its bit 0 is the run bit and its other bits read 0.
  - The status byte is at 0x24, with these bits:
    - bit 0: busy
    - bit 1: counting active
    - bit 2: second event
    - bit 3: minute event
    - bit 4: hour event
    - bit 5: day event
    - bits 6 and 7: read 0
  - Any other address reads 0x00.
- R3: While counting, seconds advance exactly on the TICKS_PER_SEC-th tick enable after the prescaler was last cleared or wrapped. Cycles without a tick enable do not count.
- R4: Seconds roll from 0x59 to 0x00 and carry into minutes. Minutes roll from 0x59 to 0x00 and carry into hours. Hours roll from 0x23 to 0x00 and carry into the day. The whole cascade happens in one clock cycle.
- R5: The last day of a month rolls to day 0x01 and increments the month. Month 0x12 rolls to 0x01 and increments the year, and year 0x99 wraps to 0x00.
- R6: February ends on day 0x29 when the year value is divisible by 4 (including 0x00), and on day 0x28 otherwise.
- R7: April, June, September and November end on day 0x30. The other months, except February, end on day 0x31.
- R8: While the run bit is 0, the fields and the prescaler hold, and status bits 0 and 1 read 0. Setting the run bit again resumes from the held prescaler value.
- R9: Busy goes high on the tick that leaves BUSY_LEAD ticks before the wrap. It falls on the edge that applies the rollover, and it is never high while stopped.
- R10: Writing the seconds field clears the prescaler and clears busy. A later rollover then needs a full TICKS_PER_SEC ticks.
- R11: The second, minute, hour and day events each last one cycle, in the cycle right after the rollover edge. An outer event occurs only together with all finer ones.
- R12: Writes to the status byte or to an unmapped address change no field and no control state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle enable at the 32768 Hz reference rate |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, decoded from reg_addr combinationally |
| busy | output | 1 | High in the window just before a rollover |
| evt_sec | output | 1 | One-cycle pulse at each second boundary |
| evt_min | output | 1 | One-cycle pulse at each minute boundary |
| evt_hour | output | 1 | One-cycle pulse at each hour boundary |
| evt_day | output | 1 | One-cycle pulse at each day boundary |

## Verification
The checker tests several properties on every cycle:
- busy is never high unless counting is active;
- each fall of busy coincides with a rollover, a stop or a register write;
- the event pulses stay nested and last one cycle;
- the seconds field holds while stopped.

The correctness of the calendar arithmetic can only be shown by the bench's scenarios. Those scenarios cover the 24-hour wrap, the month lengths, leap and non-leap Februaries, the end-of-century wrap, and the exact tick counts at which busy rises and the seconds step.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_BUSY = 2'd2
    } clk_state_e;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_t;

    localparam logic [7:0] A_SEC  = 8'h00;
    localparam logic [7:0] A_MIN  = 8'h04;
    localparam logic [7:0] A_HOUR = 8'h08;
    localparam logic [7:0] A_DAY  = 8'h0C;
    localparam logic [7:0] A_MON  = 8'h10;
    localparam logic [7:0] A_YEAR = 8'h14;
    localparam logic [7:0] A_CTRL = 8'h20;
    localparam logic [7:0] A_STAT = 8'h24;

    // One-step packed BCD increment (no range wrap)
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) begin
            bcd_inc = {v[7:4] + 4'd1, 4'd0};
        end else begin
            bcd_inc = {v[7:4], v[3:0] + 4'd1};
        end
    endfunction

    // Last day of the month in BCD, leap rule valid for 2000..2099
    function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
        logic [6:0] ybin;
        ybin = {yr[7:4], 3'b000} + {2'b00, yr[7:4], 1'b0} + {3'b000, yr[3:0]};
        case (mon)
            8'h02:   last_day = (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default: last_day = 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcd_prescaler.sv
module bcd_prescaler #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int BUSY_LEAD     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic clear,
    output logic wrap,
    output logic enter_win,
    output logic in_window
);
    localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(TICKS_PER_SEC - 1);
    localparam logic [CNT_W-1:0] ENTER = CNT_W'(TICKS_PER_SEC - BUSY_LEAD - 1);
    localparam logic [CNT_W-1:0] WSTART = CNT_W'(TICKS_PER_SEC - BUSY_LEAD);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (count_en) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    assign wrap      = count_en && (cnt_q == LAST);
    assign enter_win = count_en && (cnt_q == ENTER);
    assign in_window = (cnt_q >= WSTART);

endmodule

// File: rtl/bcd_cascade.sv
module bcd_cascade
    import bcd_clock_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt,
    output logic c_min,
    output logic c_hour,
    output logic c_day
);
    logic w_sec, w_min, w_hour, w_day, w_mon;
    logic [7:0] eom;

    always_comb begin
        eom    = last_day(cur.mon, cur.year);
        w_sec  = (cur.sec >= 8'h59);
        w_min  = w_sec && (cur.min >= 8'h59);
        w_hour = w_min && (cur.hour >= 8'h23);
        w_day  = w_hour && (cur.day >= eom);
        w_mon  = w_day && (cur.mon >= 8'h12);

        nxt.sec  = w_sec ? 8'h00 : bcd_inc(cur.sec);
        nxt.min  = !w_sec ? cur.min : ((cur.min >= 8'h59) ? 8'h00 : bcd_inc(cur.min));
        nxt.hour = !w_min ? cur.hour : ((cur.hour >= 8'h23) ? 8'h00 : bcd_inc(cur.hour));
        nxt.day  = !w_hour ? cur.day : ((cur.day >= eom) ? 8'h01 : bcd_inc(cur.day));
        nxt.mon  = !w_day ? cur.mon : ((cur.mon >= 8'h12) ? 8'h01 : bcd_inc(cur.mon));
        nxt.year = !w_mon ? cur.year : ((cur.year >= 8'h99) ? 8'h00 : bcd_inc(cur.year));

        c_min  = w_sec;
        c_hour = w_min;
        c_day  = w_hour;
    end

endmodule

// File: rtl/bcd_ctrl_fsm.sv
module bcd_ctrl_fsm
    import bcd_clock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    input  logic sec_load,
    input  logic enter_win,
    input  logic wrap,
    input  logic in_window,
    output logic busy,
    output logic running
);
    clk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (run_req) state_d = in_window ? ST_BUSY : ST_RUN;   // HALT_TO_BUSY / HALT_TO_RUN
            end
            ST_RUN: begin
                if (!run_req)       state_d = ST_HALT;                 // ANY_TO_HALT
                else if (sec_load)  state_d = ST_RUN;
                else if (enter_win) state_d = ST_BUSY;                 // RUN_TO_BUSY
            end
            ST_BUSY: begin
                if (!run_req)              state_d = ST_HALT;          // ANY_TO_HALT
                else if (sec_load || wrap) state_d = ST_RUN;           // BUSY_TO_RUN
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        busy    = (state_q == ST_BUSY);
        running = (state_q != ST_HALT);
    end

endmodule

// File: rtl/bcd_clock_core.sv
module bcd_clock_core
    import bcd_clock_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int BUSY_LEAD     = 2,
    parameter int ADDR_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              busy,
    output logic              evt_sec,
    output logic              evt_min,
    output logic              evt_hour,
    output logic              evt_day
);
    localparam int NFIELD = 6;

    cal_t       cal_q, cal_nxt;
    logic       run_q;
    logic [3:0] evt_q;
    logic       c_min, c_hour, c_day;
    logic       wrap, enter_win, in_window;
    logic       busy_w, running;
    logic [7:0] addr8;
    logic [NFIELD-1:0] fld_hit;
    logic       time_wr, sec_wr, ctrl_wr, step;

    assign addr8 = 8'(reg_addr);

    genvar gi;
    generate
        for (gi = 0; gi < NFIELD; gi++) begin : g_dec
            assign fld_hit[gi] = (addr8 == 8'(4 * gi));
        end
    endgenerate

    assign time_wr = reg_wr && (|fld_hit);
    assign sec_wr  = reg_wr && fld_hit[0];
    assign ctrl_wr = reg_wr && (addr8 == A_CTRL);
    assign step    = wrap && !time_wr;

    bcd_prescaler #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .BUSY_LEAD    (BUSY_LEAD)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (running && tick_en),
        .clear    (sec_wr),
        .wrap     (wrap),
        .enter_win(enter_win),
        .in_window(in_window)
    );

    bcd_cascade u_casc (
        .cur   (cal_q),
        .nxt   (cal_nxt),
        .c_min (c_min),
        .c_hour(c_hour),
        .c_day (c_day)
    );

    bcd_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_req  (run_q),
        .sec_load (sec_wr),
        .enter_win(enter_win),
        .wrap     (wrap),
        .in_window(in_window),
        .busy     (busy_w),
        .running  (running)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_q <= '{year: 8'h00, mon: 8'h01, day: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};
            run_q <= 1'b0;
            evt_q <= 4'b0000;
        end else begin
            if (time_wr) begin
                if (fld_hit[0]) cal_q.sec  <= reg_wdata;
                if (fld_hit[1]) cal_q.min  <= reg_wdata;
                if (fld_hit[2]) cal_q.hour <= reg_wdata;
                if (fld_hit[3]) cal_q.day  <= reg_wdata;
                if (fld_hit[4]) cal_q.mon  <= reg_wdata;
                if (fld_hit[5]) cal_q.year <= reg_wdata;
            end else if (step) begin
                cal_q <= cal_nxt;
            end
            if (ctrl_wr) run_q <= reg_wdata[0];
            evt_q <= step ? {c_day, c_hour, c_min, 1'b1} : 4'b0000;
        end
    end

    always_comb begin
        case (addr8)
            A_SEC:   reg_rdata = cal_q.sec;
            A_MIN:   reg_rdata = cal_q.min;
            A_HOUR:  reg_rdata = cal_q.hour;
            A_DAY:   reg_rdata = cal_q.day;
            A_MON:   reg_rdata = cal_q.mon;
            A_YEAR:  reg_rdata = cal_q.year;
            A_CTRL:  reg_rdata = {7'b0, run_q};
            A_STAT:  reg_rdata = {2'b00, evt_q, running, busy_w};
            default: reg_rdata = 8'h00;
        endcase
    end

    assign busy     = busy_w;
    assign evt_sec  = evt_q[0];
    assign evt_min  = evt_q[1];
    assign evt_hour = evt_q[2];
    assign evt_day  = evt_q[3];

endmodule

// File: rtl/bcd_clock_chk.sv
module bcd_clock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       running,
    input logic       reg_wr,
    input logic [7:0] sec,
    input logic [3:0] evt
);
    a_r9_busy_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> running);

    a_r9_busy_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (evt[0] || !running || $past(reg_wr)));

    a_r11_min_nest: assert property (@(posedge clk) disable iff (!rst_n)
        evt[1] |-> evt[0]);

    a_r11_hour_nest: assert property (@(posedge clk) disable iff (!rst_n)
        evt[2] |-> evt[1]);

    a_r11_day_nest: assert property (@(posedge clk) disable iff (!rst_n)
        evt[3] |-> evt[2]);

    a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        evt[0] |=> !evt[0]);

    a_r11_sec_moves: assert property (@(posedge clk) disable iff (!rst_n)
        evt[0] |-> (sec != $past(sec)));

    a_r8_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !reg_wr) |=> $stable(sec));

endmodule

bind bcd_clock_core bcd_clock_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy_w),
    .running(running),
    .reg_wr (reg_wr),
    .sec    (cal_q.sec),
    .evt    (evt_q)
);

// File: tb/bcd_clock_core_tb.sv
module bcd_clock_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TPS  = 16;
    localparam int LEAD = 3;

    logic       clk = 1'b0;
    logic       rst_n, tick_en, reg_wr;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       busy, evt_sec, evt_min, evt_hour, evt_day;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bcd_clock_core #(.TICKS_PER_SEC(TPS), .BUSY_LEAD(LEAD), .ADDR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .evt_sec(evt_sec), .evt_min(evt_min),
        .evt_hour(evt_hour), .evt_day(evt_day)
    );

    // {start year..sec, expected year..sec, expected events day,hour,min,sec}
    localparam logic [99:0] VEC [12] = '{
        {48'h00_01_01_00_00_00, 48'h00_01_01_00_00_01, 4'b0001},
        {48'h23_06_15_00_00_59, 48'h23_06_15_00_01_00, 4'b0011},
        {48'h07_03_10_12_59_59, 48'h07_03_10_13_00_00, 4'b0111},
        {48'h99_12_31_23_59_59, 48'h00_01_01_00_00_00, 4'b1111},
        {48'h24_02_28_23_59_59, 48'h24_02_29_00_00_00, 4'b1111},
        {48'h23_02_28_23_59_59, 48'h23_03_01_00_00_00, 4'b1111},
        {48'h00_02_29_23_59_59, 48'h00_03_01_00_00_00, 4'b1111},
        {48'h21_04_30_23_59_59, 48'h21_05_01_00_00_00, 4'b1111},
        {48'h21_01_30_23_59_59, 48'h21_01_31_00_00_00, 4'b1111},
        {48'h50_11_30_23_59_59, 48'h50_12_01_00_00_00, 4'b1111},
        {48'h05_08_20_09_09_09, 48'h05_08_20_09_09_10, 4'b0001},
        {48'h05_08_20_19_59_59, 48'h05_08_20_20_00_00, 4'b0111}
    };

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic peek_stat(output logic [7:0] d);
        reg_addr = 8'h24;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic set_time(input logic [47:0] t);
        for (int i = 0; i < 6; i++) wr(8'(4 * i), t[8*i +: 8]);
    endtask

    task automatic get_time(output logic [47:0] t);
        logic [7:0] b;
        for (int i = 0; i < 6; i++) begin
            rd(8'(4 * i), b);
            t[8*i +: 8] = b;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] t, t0;
        logic [7:0]  s;
        rst_n = 1'b0; tick_en = 1'b0; reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        get_time(t);
        chk("R1 fields", t, 48'h00_01_01_00_00_00);
        rd(8'h20, s); chk("R1 ctrl", 48'(s), 48'h00);
        rd(8'h24, s); chk("R1 status", 48'(s), 48'h00);

        // Table: R3 R4 R5 R6 R7 R11
        foreach (VEC[k]) begin
            wr(8'h20, 8'h00);
            set_time(VEC[k][99:52]);
            wr(8'h20, 8'h01);
            do_ticks(TPS);
            peek_stat(s);
            chk("R11 R2 status at rollover", 48'(s), 48'({2'b00, VEC[k][3:0], 2'b10}));
            get_time(t);
            chk("R3 R4 R5 R6 R7 time after one second", t, VEC[k][51:4]);
        end

        // R9 busy window and R11 one-cycle events
        wr(8'h20, 8'h00);
        set_time(48'h10_10_10_10_10_00);
        wr(8'h20, 8'h01);
        do_ticks(TPS - LEAD - 1);
        rd(8'h24, s); chk("R9 not busy before window", 48'(s), 48'h02);
        do_ticks(1);
        rd(8'h24, s); chk("R9 busy on entering window", 48'(s), 48'h03);
        do_ticks(LEAD - 1);
        rd(8'h24, s); chk("R9 busy before wrap", 48'(s), 48'h03);
        do_ticks(1);
        peek_stat(s); chk("R9 busy cleared at rollover", 48'(s), 48'h06);
        rd(8'h24, s); chk("R11 event lasts one cycle", 48'(s), 48'h02);

        // R8 stop freezes and resumes
        do_ticks(TPS - 1);
        wr(8'h20, 8'h00);
        rd(8'h24, s); chk("R8 R9 stopped status", 48'(s), 48'h00);
        do_ticks(2 * TPS);
        rd(8'h00, s); chk("R8 seconds frozen", 48'(s), 48'h01);
        wr(8'h20, 8'h01);
        rd(8'h24, s); chk("R8 resume inside window", 48'(s), 48'h03);
        do_ticks(1);
        rd(8'h00, s); chk("R8 resumed prescaler", 48'(s), 48'h02);

        // R10 seconds write resets the prescaler
        do_ticks(TPS - 2);
        wr(8'h00, 8'h30);
        rd(8'h24, s); chk("R10 busy cleared by seconds write", 48'(s), 48'h02);
        do_ticks(TPS - 1);
        rd(8'h00, s); chk("R10 no step before full second", 48'(s), 48'h30);
        do_ticks(1);
        rd(8'h00, s); chk("R10 step after full second", 48'(s), 48'h31);

        // R12 ignored writes, R2 control read back and unmapped read
        get_time(t0);
        wr(8'h24, 8'hFF);
        wr(8'h3C, 8'h55);
        rd(8'h24, s); chk("R12 status write ignored", 48'(s), 48'h02);
        get_time(t); chk("R12 fields unchanged", t, t0);
        rd(8'h20, s); chk("R2 R12 control read back", 48'(s), 48'h01);
        rd(8'h3C, s); chk("R2 unmapped reads zero", 48'(s), 48'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule